// File: doc/BRIEF.md
# Scaled Accumulate Arithmetic Datapath

This block is the arithmetic core of a fixed-point signal processing engine. It holds a 32-bit accumulator and a carry bit. Each clock cycle it combines the accumulator with a 32-bit operand and writes the result back, so a complete ALU operation takes a single cycle. The operand comes from one of two sources, chosen by a select input. The first source is a 16-bit data word, extended to 32 bits and left-shifted by 0 to 16 places. The second source is a 16x16 multiply, signed or unsigned, followed by one of four fixed product shifts.

Reading the accumulator out goes through a second scaler. That scaler left-shifts the accumulator by 0 to 7 places and returns either the upper or the lower 16 bits as a store word. Zero and negative flags are derived from the accumulator for conditional tests. Instruction decoding, memory and pipeline sequencing happen outside this block. The surrounding logic supplies the operation code, the operands and the mode inputs directly.

Top module: `sacc_core`

## Requirements
- R1: An active-low reset clears the accumulator and the carry to 0. While reset is held, and until the first operation, zero reads 1, neg reads 0 and store_word reads 0.
- R2: op codes 0 (no-op) and 13 to 15 (reserved) leave the accumulator and the carry unchanged.
- R3: With use_product=0 the operand is data_in, sign-extended when sign_ext=1 and zero-extended otherwise, then shifted left by in_shift places. An in_shift above 16 acts as 16. op 1 (load) writes the operand to the accumulator and leaves the carry unchanged.
- R4: With use_product=1 the operand is derived from the 32-bit product of data_in and mul_in. The two inputs are treated as two's complement when mul_signed=1 and as unsigned otherwise.
- R5: prod_mode scales the product: 0 leaves it as is, 1 shifts it left by 1, 2 shifts it left by 4, and 3 shifts it right by 6 with the sign bit copied in.
- R6: op 2 (add) and op 3 (add with carry-in) add the operand to the accumulator. Op 3 also adds the carry. The carry takes bit 32 of the 33-bit sum.
- R7: op 4 (subtract) computes acc minus operand. op 5 (subtract with borrow) also subtracts the inverted carry. In both, the carry is set to 1 when no borrow occurs and to 0 when one does.
- R8: op 6, op 7 and op 8 perform bitwise AND, OR and XOR of the accumulator with the operand. They leave the carry unchanged.
- R9: op 9 shifts the accumulator left by one, and the MSB moves into the carry. op 10 shifts it right by one, and the LSB moves into the carry. In both, a 0 fills the vacated bit.
- R10: op 11 rotates left through the carry: the MSB goes to the carry and the old carry goes to the LSB. op 12 rotates right through the carry: the LSB goes to the carry and the old carry goes to the MSB.
- R11: store_word is combinational. It shifts the accumulator left by out_shift (0 to 7). It returns bits 31:16 of the shifted value when out_high=1 and bits 15:0 when out_high=0.
- R12: zero is 1 exactly when the accumulator is 0, and neg equals the accumulator MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| data_in | input | 16 | Data word: input scaler source and first multiplier operand |
| mul_in | input | 16 | Second multiplier operand |
| in_shift | input | 5 | Input scaler left shift (0 to 16, saturating) |
| sign_ext | input | 1 | Sign-extend data_in before it is scaled |
| use_product | input | 1 | Select the product path as the ALU operand |
| mul_signed | input | 1 | Treat multiplier operands as two's complement |
| prod_mode | input | 2 | Product shift select |
| out_shift | input | 3 | Output scaler left shift |
| out_high | input | 1 | Select the upper half of the scaled accumulator |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry bit |
| zero | output | 1 | Accumulator equals zero |
| neg | output | 1 | Accumulator MSB |
| store_word | output | 16 | Scaled accumulator half |

## Verification
The accumulator and the carry are the only state. A wrong value in either appears on acc or carry one edge after the faulty operation. It then spreads further: add with carry, subtract with borrow and the rotates all read the carry back. A scaler fault can only show up once the accumulator has been loaded through that path, so every shift setting and product mode is loaded and compared on the next cycle. The flags and the store word follow the accumulator combinationally, so they are checked in the same cycle as the accumulator.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned ACC_W  = 2 * DATA_W;

  // Operation codes driven on the op port
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LOAD = 4'd1,
    OP_ADD  = 4'd2,
    OP_ADDC = 4'd3,
    OP_SUB  = 4'd4,
    OP_SUBB = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12
  } alu_op_e;

  // Product scaling modes
  typedef enum logic [1:0] {
    PM_NONE   = 2'd0,
    PM_LEFT_A = 2'd1,
    PM_LEFT_B = 2'd2,
    PM_RIGHT  = 2'd3
  } prod_mode_e;

  localparam int unsigned PSH_LEFT_A = 1;
  localparam int unsigned PSH_LEFT_B = 4;
  localparam int unsigned PSH_RIGHT  = 6;

endpackage

// File: rtl/sacc_in_scaler.sv
module sacc_in_scaler #(
  parameter int unsigned DW     = 16,
  parameter int unsigned MAX_SH = 16,
  parameter int unsigned SHW    = 5
) (
  input  logic [DW-1:0]   word,
  input  logic            sign_ext,
  input  logic [SHW-1:0]  shamt,
  output logic [2*DW-1:0] scaled
);
  localparam int unsigned AW = 2 * DW;

  // Extend to accumulator width, then shift left with a saturated count
  function automatic logic [AW-1:0] scale_word(input logic [DW-1:0] w,
                                                input logic sx,
                                                input logic [SHW-1:0] n);
    logic [AW-1:0] ext;
    logic [SHW-1:0] cnt;
    ext = sx ? {{DW{w[DW-1]}}, w} : {{DW{1'b0}}, w};
    cnt = (32'(n) > MAX_SH) ? SHW'(MAX_SH) : n;
    return ext << cnt;
  endfunction

  assign scaled = scale_word(word, sign_ext, shamt);

endmodule

// File: rtl/sacc_product.sv
module sacc_product
  import sacc_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0]   mul_a,
  input  logic [DW-1:0]   mul_b,
  input  logic            is_signed,
  input  logic [1:0]      mode,
  output logic [2*DW-1:0] scaled
);
  localparam int unsigned AW = 2 * DW;
  localparam int unsigned XW = AW + 2;

  // One extra bit per operand makes a single signed multiplier cover both cases
  function automatic logic [AW-1:0] full_product(input logic [DW-1:0] a,
                                                 input logic [DW-1:0] b,
                                                 input logic sg);
    logic signed [DW:0] xa;
    logic signed [DW:0] xb;
    logic signed [XW-1:0] p;
    xa = $signed({sg & a[DW-1], a});
    xb = $signed({sg & b[DW-1], b});
    p  = XW'(xa) * XW'(xb);
    return p[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] mode_shift(input logic [AW-1:0] p,
                                               input logic [1:0] m);
    logic [AW-1:0] r;
    case (prod_mode_e'(m))
      PM_LEFT_A: r = p << PSH_LEFT_A;
      PM_LEFT_B: r = p << PSH_LEFT_B;
      PM_RIGHT:  r = $unsigned($signed(p) >>> PSH_RIGHT);
      default:   r = p;
    endcase
    return r;
  endfunction

  logic [AW-1:0] raw;

  assign raw    = full_product(mul_a, mul_b, is_signed);
  assign scaled = mode_shift(raw, mode);

endmodule

// File: rtl/sacc_alu.sv
module sacc_alu
  import sacc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [3:0]    op,
  input  logic [AW-1:0] acc_q,
  input  logic          carry_q,
  input  logic [AW-1:0] opnd,
  output logic [AW-1:0] acc_d,
  output logic          carry_d,
  output logic          acc_we,
  output logic          carry_we
);
  localparam int unsigned SW = AW + 1;

  // Add with explicit carry-in; subtract uses the inverted operand
  function automatic logic [SW-1:0] add_cin(input logic [AW-1:0] x,
                                            input logic [AW-1:0] y,
                                            input logic cin);
    return {1'b0, x} + {1'b0, y} + SW'(cin);
  endfunction

  logic [SW-1:0] sum;

  always_comb begin
    acc_d    = acc_q;
    carry_d  = carry_q;
    acc_we   = 1'b1;
    carry_we = 1'b1;
    sum      = '0;
    case (alu_op_e'(op))
      OP_LOAD: begin
        acc_d    = opnd;
        carry_we = 1'b0;
      end
      OP_ADD:  begin sum = add_cin(acc_q, opnd, 1'b0);    {carry_d, acc_d} = sum; end
      OP_ADDC: begin sum = add_cin(acc_q, opnd, carry_q); {carry_d, acc_d} = sum; end
      OP_SUB:  begin sum = add_cin(acc_q, ~opnd, 1'b1);   {carry_d, acc_d} = sum; end
      OP_SUBB: begin sum = add_cin(acc_q, ~opnd, carry_q); {carry_d, acc_d} = sum; end
      OP_AND:  begin acc_d = acc_q & opnd; carry_we = 1'b0; end
      OP_OR:   begin acc_d = acc_q | opnd; carry_we = 1'b0; end
      OP_XOR:  begin acc_d = acc_q ^ opnd; carry_we = 1'b0; end
      OP_SHL:  begin carry_d = acc_q[AW-1]; acc_d = {acc_q[AW-2:0], 1'b0}; end
      OP_SHR:  begin carry_d = acc_q[0];    acc_d = {1'b0, acc_q[AW-1:1]}; end
      OP_ROL:  begin carry_d = acc_q[AW-1]; acc_d = {acc_q[AW-2:0], carry_q}; end
      OP_ROR:  begin carry_d = acc_q[0];    acc_d = {carry_q, acc_q[AW-1:1]}; end
      default: begin acc_we = 1'b0; carry_we = 1'b0; end
    endcase
  end

endmodule

// File: rtl/sacc_out_scaler.sv
module sacc_out_scaler #(
  parameter int unsigned DW  = 16,
  parameter int unsigned SHW = 3
) (
  input  logic [2*DW-1:0] acc_q,
  input  logic [SHW-1:0]  shamt,
  input  logic            take_high,
  output logic [DW-1:0]   word
);
  localparam int unsigned AW = 2 * DW;

  function automatic logic [DW-1:0] pick_half(input logic [AW-1:0] a,
                                               input logic [SHW-1:0] n,
                                               input logic hi);
    logic [AW-1:0] s;
    s = a << n;
    return hi ? s[AW-1:DW] : s[DW-1:0];
  endfunction

  assign word = pick_half(acc_q, shamt, take_high);

endmodule

// File: rtl/sacc_core.sv
module sacc_core
  import sacc_pkg::*;
#(
  parameter int unsigned DW       = sacc_pkg::DATA_W,
  parameter int unsigned IN_SHW   = 5,
  parameter int unsigned IN_MAX   = 16,
  parameter int unsigned OUT_SHW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [DW-1:0]     data_in,
  input  logic [DW-1:0]     mul_in,
  input  logic [IN_SHW-1:0] in_shift,
  input  logic              sign_ext,
  input  logic              use_product,
  input  logic              mul_signed,
  input  logic [1:0]        prod_mode,
  input  logic [OUT_SHW-1:0] out_shift,
  input  logic              out_high,
  output logic [2*DW-1:0]   acc,
  output logic              carry,
  output logic              zero,
  output logic              neg,
  output logic [DW-1:0]     store_word
);
  localparam int unsigned AW = 2 * DW;

  // Named internal events, visible to the bound checker
  logic [AW-1:0] in_scaled;
  logic [AW-1:0] prod_scaled;
  logic [AW-1:0] alu_opnd;
  logic [AW-1:0] alu_acc_d;
  logic          alu_carry_d;
  logic          acc_we;
  logic          carry_we;

  logic [AW-1:0] acc_q;
  logic          carry_q;

  sacc_in_scaler #(.DW(DW), .MAX_SH(IN_MAX), .SHW(IN_SHW)) u_in (
    .word     (data_in),
    .sign_ext (sign_ext),
    .shamt    (in_shift),
    .scaled   (in_scaled)
  );

  sacc_product #(.DW(DW)) u_prod (
    .mul_a     (data_in),
    .mul_b     (mul_in),
    .is_signed (mul_signed),
    .mode      (prod_mode),
    .scaled    (prod_scaled)
  );

  assign alu_opnd = use_product ? prod_scaled : in_scaled;

  sacc_alu #(.AW(AW)) u_alu (
    .op       (op),
    .acc_q    (acc_q),
    .carry_q  (carry_q),
    .opnd     (alu_opnd),
    .acc_d    (alu_acc_d),
    .carry_d  (alu_carry_d),
    .acc_we   (acc_we),
    .carry_we (carry_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (acc_we)   acc_q   <= alu_acc_d;
      if (carry_we) carry_q <= alu_carry_d;
    end
  end

  sacc_out_scaler #(.DW(DW), .SHW(OUT_SHW)) u_out (
    .acc_q     (acc_q),
    .shamt     (out_shift),
    .take_high (out_high),
    .word      (store_word)
  );

  assign acc   = acc_q;
  assign carry = carry_q;
  assign zero  = (acc_q == '0);
  assign neg   = acc_q[AW-1];

endmodule

// File: rtl/sacc_chk.sv
module sacc_chk
  import sacc_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned OUT_SHW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         op,
  input logic [2*DW-1:0]    acc,
  input logic               carry,
  input logic [2*DW-1:0]    alu_opnd,
  input logic [DW-1:0]      store_word,
  input logic [OUT_SHW-1:0] out_shift,
  input logic               out_high
);
  localparam int unsigned AW = 2 * DW;

  logic is_hold;
  assign is_hold = (op == OP_NOP) || (op > OP_ROR);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc == '0) && !carry);  // R1
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    is_hold |=> $stable(acc) && $stable(carry));  // R2
  AST_LOAD_OPND: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (acc == $past(alu_opnd)) && $stable(carry));  // R3
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD) |=> {carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(alu_opnd)}));  // R6
  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AND || op == OP_OR || op == OP_XOR) |=> $stable(carry));  // R8
  AST_SHL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHL) |=> (carry == $past(acc[AW-1])) && !acc[0]);  // R9
  AST_ROL_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL) |=> (carry == $past(acc[AW-1])) && (acc[0] == $past(carry)));  // R10
  AST_ROR_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROR) |=> (carry == $past(acc[0])) && (acc[AW-1] == $past(carry)));  // R10
  AST_STORE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_shift == '0 && !out_high) |-> store_word == acc[DW-1:0]);  // R11
  AST_STORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_shift == '0 && out_high) |-> store_word == acc[AW-1:DW]);  // R11

endmodule

bind sacc_core sacc_chk #(.DW(DW), .OUT_SHW(OUT_SHW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op         (op),
  .acc        (acc),
  .carry      (carry),
  .alu_opnd   (alu_opnd),
  .store_word (store_word),
  .out_shift  (out_shift),
  .out_high   (out_high)
);

// File: tb/sacc_core_test.sv
module sacc_core_test;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 5000;
  localparam int NV = 24;

  // Vector: op[49:46] a[45:30] b[29:14] sh[13:9] sx[8] src[7] ms[6] pm[5:4] osh[3:1] ohi[0]
  typedef logic [49:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {4'd1,  16'h8001, 16'h0000, 5'd4,  1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 1'b1},
    {4'd1,  16'h8001, 16'h0000, 5'd16, 1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 1'b0},
    {4'd2,  16'h8000, 16'h0000, 5'd16, 1'b0, 1'b0, 1'b0, 2'd0, 3'd7, 1'b1},
    {4'd3,  16'h0001, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd1, 1'b0},
    {4'd4,  16'h0005, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0},
    {4'd5,  16'h7FFF, 16'h0000, 5'd20, 1'b1, 1'b0, 1'b0, 2'd0, 3'd2, 1'b1},
    {4'd5,  16'h0001, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0},
    {4'd1,  16'hFFFF, 16'h0002, 5'd0,  1'b0, 1'b1, 1'b1, 2'd0, 3'd0, 1'b1},
    {4'd1,  16'hFFFF, 16'h0002, 5'd0,  1'b0, 1'b1, 1'b0, 2'd1, 3'd5, 1'b1},
    {4'd2,  16'h8000, 16'h7FFF, 5'd0,  1'b0, 1'b1, 1'b1, 2'd3, 3'd0, 1'b0},
    {4'd1,  16'h1234, 16'h5678, 5'd0,  1'b0, 1'b1, 1'b0, 2'd2, 3'd4, 1'b0},
    {4'd6,  16'h0FF0, 16'h0000, 5'd8,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b1},
    {4'd7,  16'hF00F, 16'h0000, 5'd4,  1'b1, 1'b0, 1'b0, 2'd0, 3'd6, 1'b1},
    {4'd8,  16'hFFFF, 16'h0000, 5'd0,  1'b1, 1'b0, 1'b0, 2'd0, 3'd1, 1'b0},
    {4'd9,  16'h0000, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0},
    {4'd11, 16'h0000, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b1},
    {4'd12, 16'h0000, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd2, 1'b0},
    {4'd10, 16'h0000, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b1},
    {4'd15, 16'h1234, 16'h0000, 5'd3,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0},
    {4'd0,  16'hABCD, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b1},
    {4'd1,  16'h0000, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0},
    {4'd4,  16'h0001, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b1},
    {4'd2,  16'h0001, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0},
    {4'd1,  16'h8000, 16'h8000, 5'd0,  1'b0, 1'b1, 1'b1, 2'd3, 3'd7, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] data_in = '0;
  logic [15:0] mul_in = '0;
  logic [4:0]  in_shift = '0;
  logic        sign_ext = 1'b0;
  logic        use_product = 1'b0;
  logic        mul_signed = 1'b0;
  logic [1:0]  prod_mode = '0;
  logic [2:0]  out_shift = '0;
  logic        out_high = 1'b0;
  logic [31:0] acc;
  logic        carry;
  logic        zero;
  logic        neg;
  logic [15:0] store_word;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_acc;
  logic        m_c;

  always #(CLK_P / 2) clk = ~clk;

  sacc_core uut (
    .clk(clk), .rst_n(rst_n), .op(op), .data_in(data_in), .mul_in(mul_in),
    .in_shift(in_shift), .sign_ext(sign_ext), .use_product(use_product),
    .mul_signed(mul_signed), .prod_mode(prod_mode), .out_shift(out_shift),
    .out_high(out_high), .acc(acc), .carry(carry), .zero(zero), .neg(neg),
    .store_word(store_word)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Operand as the requirements describe it, computed with wide integers
  function automatic logic [31:0] mdl_opnd(input vec_t v);
    longint x;
    int n;
    if (!v[7]) begin
      x = v[8] ? longint'($signed(v[45:30])) : longint'(v[45:30]);
      n = (int'(v[13:9]) > 16) ? 16 : int'(v[13:9]);
      x = x << n;
      return x[31:0];
    end
    if (v[6]) x = longint'($signed(v[45:30])) * longint'($signed(v[29:14]));
    else      x = longint'(v[45:30]) * longint'(v[29:14]);
    case (v[5:4])
      2'd1: x = x << 1;
      2'd2: x = x << 4;
      2'd3: x = longint'($signed(x[31:0])) >>> 6;
      default: ;
    endcase
    return x[31:0];
  endfunction

  task automatic mdl_step(input vec_t v);
    logic [31:0] o;
    longint s;
    logic b;
    logic oc;
    o = mdl_opnd(v);
    oc = m_c;
    case (v[49:46])
      4'd1: m_acc = o;
      4'd2: begin s = longint'(m_acc) + longint'(o); m_c = s[32]; m_acc = s[31:0]; end
      4'd3: begin s = longint'(m_acc) + longint'(o) + longint'(oc); m_c = s[32]; m_acc = s[31:0]; end
      4'd4: begin m_c = (m_acc >= o); m_acc = m_acc - o; end
      4'd5: begin
        b = !oc;
        m_c = (longint'(m_acc) >= longint'(o) + longint'(b));
        m_acc = m_acc - o - 32'(b);
      end
      4'd6: m_acc = m_acc & o;
      4'd7: m_acc = m_acc | o;
      4'd8: m_acc = m_acc ^ o;
      4'd9:  begin m_c = m_acc[31]; m_acc = m_acc << 1; end
      4'd10: begin m_c = m_acc[0];  m_acc = m_acc >> 1; end
      4'd11: begin m_c = m_acc[31]; m_acc = {m_acc[30:0], oc}; end
      4'd12: begin m_c = m_acc[0];  m_acc = {oc, m_acc[31:1]}; end
      default: ;
    endcase
  endtask

  function automatic string tag_of(input vec_t v);
    case (v[49:46])
      4'd1: return v[7] ? ((v[5:4] != 2'd0) ? "R5" : "R4") : "R3";
      4'd2, 4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6, 4'd7, 4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      4'd11, 4'd12: return "R10";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [15:0] mdl_store(input logic [31:0] a,
                                            input logic [2:0] n, input logic hi);
    logic [63:0] w;
    w = {32'b0, a} * (64'd1 << n);
    return hi ? w[31:16] : w[15:0];
  endfunction

  task automatic apply(input vec_t v);
    op = v[49:46]; data_in = v[45:30]; mul_in = v[29:14]; in_shift = v[13:9];
    sign_ext = v[8]; use_product = v[7]; mul_signed = v[6]; prod_mode = v[5:4];
    out_shift = v[3:1]; out_high = v[0];
  endtask

  task automatic check_outputs(input string tag);
    chk(tag, "acc", acc, m_acc);
    chk(tag, "carry", 32'(carry), 32'(m_c));
    chk("R11", "store_word", 32'(store_word), 32'(mdl_store(m_acc, out_shift, out_high)));
    chk("R12", "zero", 32'(zero), 32'(m_acc == 32'd0));
    chk("R12", "neg", 32'(neg), 32'(m_acc[31]));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_acc = '0;
    m_c = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset acc", acc, 32'd0);
    chk("R1", "reset carry", 32'(carry), 32'd0);
    chk("R1", "reset zero", 32'(zero), 32'd1);
    chk("R1", "reset store", 32'(store_word), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "acc after release", acc, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(posedge clk);
      mdl_step(VEC[i]);
      @(negedge clk);
      check_outputs(tag_of(VEC[i]));
    end

    // Mid-run reset clears state
    op = 4'd0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid reset acc", acc, 32'd0);
    chk("R1", "mid reset carry", 32'(carry), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Hand-worked: -1 * 2 signed, arithmetic right by 6 gives all ones
    apply({4'd1, 16'hFFFF, 16'h0002, 5'd0, 1'b0, 1'b1, 1'b1, 2'd3, 3'd0, 1'b0});
    @(negedge clk);
    chk("R5", "signed product >>>6", acc, 32'hFFFF_FFFF);
    chk("R12", "neg on all ones", 32'(neg), 32'd1);

    // Rotate right with carry 0: MSB clears, carry takes LSB
    op = 4'd12;
    @(negedge clk);
    chk("R10", "ror acc", acc, 32'h7FFF_FFFF);
    chk("R10", "ror carry", 32'(carry), 32'd1);
    op = 4'd0;
    out_shift = 3'd7;
    out_high = 1'b1;
    #1;
    chk("R11", "store hi <<7", 32'(store_word), 32'h0000_FFFF);
    out_high = 1'b0;
    #1;
    chk("R11", "store lo <<7", 32'(store_word), 32'h0000_FF80);
    chk("R12", "zero clear", 32'(zero), 32'd0);

    // Reserved code 14 leaves acc and carry alone
    op = 4'd14;
    data_in = 16'h5555;
    @(negedge clk);
    chk("R2", "reserved op acc", acc, 32'h7FFF_FFFF);
    chk("R2", "reserved op carry", 32'(carry), 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule